// File: doc/BRIEF.md
# Tamper-Triggered Backup Register Bank

This block keeps a bank of twenty 32-bit general-purpose backup words and watches a single tamper input. When tamper detection is armed and the programmed condition is seen on the input, hardware clears every backup word to zero. It also sets a sticky "bank was wiped" status bit and a tamper interrupt flag. The interrupt output follows that flag while the tamper interrupt enable is set.

Software uses a simple word-addressed register port. A write is accepted on every cycle that `bus_we` is high; there is no back-pressure. Read data is combinational from `bus_addr`. The control word selects edge or level detection and the active polarity, arms detection, and opens or closes access to the backup bank. A read-only ready bit in the control word drops for a fixed update window after any register write.

Top module: `tamper_wipe_bank`

## Requirements
- R1: After reset the control word (0x3C) reads 0x80 (only ready, bit 7, set), the tamper flag word (0x2C) and tamper enable word (0x28) read 0, and `irq` is 0.
- R2: With bank access enabled (control bit 2 = 1), backup word i (0..19) at address 0x40 + 4*i stores a written value and reads it back unchanged. Addresses past the last word (0x90 and above) read 0.
- R3: With bank access disabled (control bit 2 = 0), backup words read as 0 and writes to them are ignored. The previous contents reappear once access is enabled again.
- R4: In edge mode (control bit 3 = 1) with polarity high (control bit 1 = 1) and detection armed (bit 0 = 1), a rising transition of `tamper_pin` clears all backup words. A falling transition does not.
- R5: In edge mode with polarity low (bit 1 = 0), a falling transition of `tamper_pin` wipes the bank and a rising transition does not.
- R6: In level mode (bit 3 = 0), the wipe holds for as long as `tamper_pin` sits at the active level. Bank writes made during that time are lost, and writes take effect again once the pin returns to its inactive level.
- R7: With detection disarmed (bit 0 = 0), no pin activity changes the bank, the wiped status or the tamper flag.
- R8: The wiped status (control bit 5) is set by a wipe and stays set until a control write with bit 5 = 1. A control write with bit 5 = 0 leaves it set.
- R9: The tamper flag (bit 2 of 0x2C) is set by a detected event and cleared by writing 1 to that bit. `irq` is high exactly when this flag and the tamper enable (bit 2 of 0x28) are both set.
- R10: After any register write the ready bit (control bit 7) reads 0 for the two following cycles and then 1.
- R11: The tamper input passes through a two-stage synchronizer. A pin change made just before a clock edge has cleared the bank by the third rising edge after that change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tamper_pin | input | 1 | Asynchronous tamper input |
| bus_we | input | 1 | Register write strobe, one write per cycle |
| bus_addr | input | 8 | Byte address of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Tamper interrupt request |

## Verification
The wipe is tried with rising and falling transitions under each polarity in edge mode. This separates a true transition detector from one that reacts to level. It also shows that only the selected direction triggers. Level mode is driven with a held active level while writes are attempted, which tells a wipe that is held apart from a single-cycle clear. Disarmed detection and a closed bank are exercised with pin toggles and writes, and the surviving contents are read back afterwards. A table of writes to scattered backup words, including the first and last, checks address decoding against neighbouring words and the address just past the bank.

// File: rtl/tw_pkg.sv
package tw_pkg;
  // Register byte offsets used by the decoder
  localparam logic [7:0] OFS_IEN  = 8'h28;
  localparam logic [7:0] OFS_FLAG = 8'h2C;
  localparam logic [7:0] OFS_CTRL = 8'h3C;

  // Control word bit positions
  localparam int B_ARM    = 0;
  localparam int B_POL    = 1;
  localparam int B_OPEN   = 2;
  localparam int B_EDGE   = 3;
  localparam int B_WIPED  = 5;
  localparam int B_READY  = 7;
  localparam int B_TAMPER = 2;

  typedef struct packed {
    logic armed;
    logic pol_high;
    logic bank_open;
    logic edge_mode;
  } tw_cfg_t;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pin_i,
  input  tw_pkg::tw_cfg_t cfg_i,
  output logic           event_o
);
  logic [STAGES-1:0] shreg;
  logic              prev_q;
  logic              cur;

  assign cur = shreg[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      prev_q <= 1'b0;
    end else begin
      shreg  <= {shreg[STAGES-2:0], pin_i};
      prev_q <= cur;
    end
  end

  logic rise, fall, lvl_hit;
  assign rise    = cur & ~prev_q;
  assign fall    = ~cur & prev_q;
  assign lvl_hit = (cur == cfg_i.pol_high);

  always_comb begin
    if (!cfg_i.armed)          event_o = 1'b0;
    else if (cfg_i.edge_mode)  event_o = cfg_i.pol_high ? rise : fall;
    else                       event_o = lvl_hit;
  end
endmodule

// File: rtl/tw_spare_bank.sv
module tw_spare_bank #(
  parameter int N = 20,
  parameter int W = 32,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wipe_i,
  input  logic          wr_en_i,
  input  logic [IW-1:0] idx_i,
  input  logic [W-1:0]  wr_data_i,
  output logic [W-1:0]  rd_data_o,
  output logic          any_nz_o
);
  logic [W-1:0] word_q [N];
  logic [N-1:0] nz;

  for (genvar g = 0; g < N; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                     word_q[g] <= '0;
      else if (wipe_i)                                word_q[g] <= '0;
      else if (wr_en_i && idx_i == IW'(g))            word_q[g] <= wr_data_i;
    end
    assign nz[g] = |word_q[g];
  end

  assign rd_data_o = (int'(idx_i) < N) ? word_q[idx_i] : '0;
  assign any_nz_o  = |nz;
endmodule

// File: rtl/tw_ctrl.sv
module tw_ctrl #(
  parameter int UPD_LAT = 2,
  localparam int CW = $clog2(UPD_LAT + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            any_we_i,
  input  logic            ctrl_we_i,
  input  logic            ien_we_i,
  input  logic            flag_we_i,
  input  logic [7:0]      wdata_i,
  input  logic            event_i,
  output tw_pkg::tw_cfg_t cfg_o,
  output logic            wiped_o,
  output logic            flag_o,
  output logic            ien_o,
  output logic            ready_o
);
  import tw_pkg::*;
  logic [CW-1:0] busy_q;
  logic unused_bits;
  assign unused_bits = ^{wdata_i[7:6], wdata_i[4]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_o   <= '0;
      wiped_o <= 1'b0;
      flag_o  <= 1'b0;
      ien_o   <= 1'b0;
      busy_q  <= '0;
    end else begin
      if (ctrl_we_i) begin
        cfg_o.armed     <= wdata_i[B_ARM];
        cfg_o.pol_high  <= wdata_i[B_POL];
        cfg_o.bank_open <= wdata_i[B_OPEN];
        cfg_o.edge_mode <= wdata_i[B_EDGE];
      end
      // set has priority over write-one-to-clear
      if (event_i)                              wiped_o <= 1'b1;
      else if (ctrl_we_i && wdata_i[B_WIPED])   wiped_o <= 1'b0;
      if (event_i)                              flag_o  <= 1'b1;
      else if (flag_we_i && wdata_i[B_TAMPER])  flag_o  <= 1'b0;
      if (ien_we_i)                             ien_o   <= wdata_i[B_TAMPER];
      if (any_we_i)                             busy_q  <= CW'(UPD_LAT);
      else if (busy_q != '0)                    busy_q  <= busy_q - 1'b1;
    end
  end

  assign ready_o = (busy_q == '0);
endmodule

// File: rtl/tamper_wipe_bank.sv
module tamper_wipe_bank #(
  parameter int NUM_SPARE   = 20,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 8,
  parameter int SPARE_BASE  = 'h40,
  parameter int SYNC_STAGES = 2,
  parameter int UPD_LAT     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tamper_pin,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  import tw_pkg::*;
  localparam int IW = $clog2(NUM_SPARE);

  tw_cfg_t           cfg;
  logic              wipe_evt, wiped, flag, ien, ready, bank_nonzero;
  logic [ADDR_W-1:0] off;
  logic              spare_hit;
  logic [IW-1:0]     idx;
  logic [DATA_W-1:0] bank_rd;

  assign off       = bus_addr - ADDR_W'(SPARE_BASE);
  assign spare_hit = (int'(bus_addr) >= SPARE_BASE) && (off[1:0] == 2'b00)
                     && (int'(off[ADDR_W-1:2]) < NUM_SPARE);
  assign idx       = off[IW+1:2];

  tw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(tamper_pin), .cfg_i(cfg), .event_o(wipe_evt)
  );

  tw_spare_bank #(.N(NUM_SPARE), .W(DATA_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wipe_i(wipe_evt),
    .wr_en_i(bus_we && spare_hit && cfg.bank_open),
    .idx_i(idx), .wr_data_i(bus_wdata),
    .rd_data_o(bank_rd), .any_nz_o(bank_nonzero)
  );

  tw_ctrl #(.UPD_LAT(UPD_LAT)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .any_we_i(bus_we),
    .ctrl_we_i(bus_we && bus_addr == ADDR_W'(OFS_CTRL)),
    .ien_we_i(bus_we && bus_addr == ADDR_W'(OFS_IEN)),
    .flag_we_i(bus_we && bus_addr == ADDR_W'(OFS_FLAG)),
    .wdata_i(bus_wdata[7:0]), .event_i(wipe_evt),
    .cfg_o(cfg), .wiped_o(wiped), .flag_o(flag), .ien_o(ien), .ready_o(ready)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFS_CTRL)) begin
      bus_rdata[B_ARM]   = cfg.armed;
      bus_rdata[B_POL]   = cfg.pol_high;
      bus_rdata[B_OPEN]  = cfg.bank_open;
      bus_rdata[B_EDGE]  = cfg.edge_mode;
      bus_rdata[B_WIPED] = wiped;
      bus_rdata[B_READY] = ready;
    end else if (bus_addr == ADDR_W'(OFS_IEN)) begin
      bus_rdata[B_TAMPER] = ien;
    end else if (bus_addr == ADDR_W'(OFS_FLAG)) begin
      bus_rdata[B_TAMPER] = flag;
    end else if (spare_hit && cfg.bank_open) begin
      bus_rdata = bank_rd;
    end
  end

  assign irq = flag & ien;
endmodule

// File: rtl/tw_checker.sv
module tw_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_we,
  input logic [7:0] bus_addr,
  input logic       wdata_b2,
  input logic       wipe,
  input logic       bank_nz,
  input logic       bank_open,
  input logic       ready,
  input logic       wiped,
  input logic       flag
);
  p_ready_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |=> !ready);
  p_ready_back_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_we && !$past(bus_we)) |=> ready);
  p_wipe_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wipe |=> !bank_nz);
  p_write_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wipe && bus_we) |=> !bank_nz);
  p_wiped_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wipe |=> wiped);
  p_flag_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wipe |=> flag);
  p_flag_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !(bus_we && bus_addr == 8'h2C && wdata_b2)) |=> flag);
  p_closed_bank_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!bank_open && !wipe) |=> $stable(bank_nz));
endmodule

bind tamper_wipe_bank tw_checker u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .wdata_b2(bus_wdata[2]), .wipe(wipe_evt), .bank_nz(bank_nonzero),
  .bank_open(cfg.bank_open), .ready(ready), .wiped(wiped), .flag(flag)
);

// File: tb/tamper_wipe_bank_tb_top.sv
module tamper_wipe_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tamper_pin = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  int          errors = 0;
  int          checks = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  tamper_wipe_bank dut_i (
    .clk(clk), .rst_n(rst_n), .tamper_pin(tamper_pin), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // {word index, data}
  localparam logic [36:0] VEC [5] = '{
    {5'd0,  32'hCAFE_0001}, {5'd1,  32'h1234_5678}, {5'd7,  32'hA5A5_5A5A},
    {5'd18, 32'h0BAD_F00D}, {5'd19, 32'hFFFF_FFFF}
  };

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] sa(int i);
    return 8'(8'h40 + 4 * i);
  endfunction

  logic [31:0] v;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(8'h3C, v); chk("R1 ctrl", v, 32'h80);
    rd(8'h2C, v); chk("R1 flag", v, 0);
    rd(8'h28, v); chk("R1 ien", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);

    // R2 table walk
    wr(8'h3C, 32'h04);
    for (int i = 0; i < 5; i++) wr(sa(int'(VEC[i][36:32])), VEC[i][31:0]);
    for (int i = 0; i < 5; i++) begin
      rd(sa(int'(VEC[i][36:32])), v); chk("R2 readback", v, VEC[i][31:0]);
    end
    rd(8'h90, v); chk("R2 past end", v, 0);
    rd(sa(2), v); chk("R2 untouched neighbour", v, 0);

    // R3 closed bank
    wr(8'h3C, 32'h00);
    wr(sa(0), 32'hDEAD_BEEF);
    rd(sa(0), v); chk("R3 closed read", v, 0);
    wr(8'h3C, 32'h04);
    rd(sa(0), v); chk("R3 write ignored", v, 32'hCAFE_0001);

    // R10 ready window
    @(negedge clk); bus_we = 1'b1; bus_addr = 8'h28; bus_wdata = 32'h0;
    @(negedge clk); bus_we = 1'b0; bus_addr = 8'h3C; #1;
    chk("R10 ready cycle1", {31'b0, bus_rdata[7]}, 0);
    @(negedge clk); #1 chk("R10 ready cycle2", {31'b0, bus_rdata[7]}, 0);
    @(negedge clk); #1 chk("R10 ready back", {31'b0, bus_rdata[7]}, 1);

    // R7 disarmed, edge mode, bank open
    wr(8'h3C, 32'h0C);
    tamper_pin = 1'b1; settle(4); tamper_pin = 1'b0; settle(4);
    rd(sa(1), v); chk("R7 bank kept", v, 32'h1234_5678);
    rd(8'h2C, v); chk("R7 no flag", v, 0);
    rd(8'h3C, v); chk("R7 no wiped", v & 32'h7F, 32'h0C);

    // R4 rising edge, polarity high; R11 latency
    wr(8'h3C, 32'h0F);
    @(negedge clk); tamper_pin = 1'b1;
    @(negedge clk); @(negedge clk); bus_addr = sa(19); #1;
    chk("R11 not yet wiped", bus_rdata, 32'hFFFF_FFFF);
    @(negedge clk); #1 chk("R11 wiped by third edge", bus_rdata, 0);
    rd(sa(0), v); chk("R4 first word wiped", v, 0);
    rd(sa(7), v); chk("R4 middle word wiped", v, 0);
    rd(8'h3C, v); chk("R8 wiped set", v, 32'hAF);
    rd(8'h2C, v); chk("R9 flag set", v, 32'h4);
    chk("R9 irq masked", {31'b0, irq}, 0);
    wr(8'h28, 32'h4); settle(1);
    chk("R9 irq on", {31'b0, irq}, 1);
    wr(8'h2C, 32'h4); settle(1);
    chk("R9 irq cleared", {31'b0, irq}, 0);
    wr(8'h3C, 32'h0F); settle(3);
    rd(8'h3C, v); chk("R8 write zero keeps", v, 32'hAF);
    wr(8'h3C, 32'h2F); settle(3);
    rd(8'h3C, v); chk("R8 w1c", v, 32'h8F);
    wr(sa(3), 32'h3333_0000);
    tamper_pin = 1'b0; settle(4);
    rd(sa(3), v); chk("R4 falling ignored", v, 32'h3333_0000);

    // R5 falling edge, polarity low
    wr(8'h3C, 32'h0D);
    tamper_pin = 1'b1; settle(4);
    rd(sa(3), v); chk("R5 rising ignored", v, 32'h3333_0000);
    tamper_pin = 1'b0; settle(4);
    rd(sa(3), v); chk("R5 falling wipes", v, 0);
    rd(8'h2C, v); chk("R5 flag", v, 32'h4);
    wr(8'h2C, 32'h4);

    // R6 level mode, polarity high
    wr(8'h3C, 32'h07);
    wr(sa(4), 32'h11);
    rd(sa(4), v); chk("R6 before level", v, 32'h11);
    tamper_pin = 1'b1; settle(4);
    rd(sa(4), v); chk("R6 wiped", v, 0);
    wr(sa(4), 32'h22);
    rd(sa(4), v); chk("R6 write blocked", v, 0);
    tamper_pin = 1'b0; settle(4);
    wr(sa(4), 32'h33);
    rd(sa(4), v); chk("R6 write after release", v, 32'h33);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule